// File: doc/BRIEF.md
# Packed SIMD Logical Left Shifter

This block is the left-shift slice of a SIMD execution datapath. A vector of up to 256 bits is cut into equal elements of 16, 32 or 64 bits, and every element is shifted left by one common amount. Zeros enter at the low end of each element, and no bit crosses from one element into the next. The shift amount comes from one of two places. It can be an 8-bit immediate. It can also be the low 64 bits of a 128-bit count vector, taken as one unsigned number. Any amount that reaches the element width clears the whole active result. The amount is never reduced modulo the width.

A width/mode select chooses how many bits are active and what happens above them. In 64-bit mode and in legacy 128-bit mode, the destination bits above the active width keep the old destination value. In extended 128-bit mode those upper bits become zero. In 256-bit mode the whole vector is shifted. The issuing stage gives the old destination and the source vector side by side, so one path serves both the two-operand forms and the three-operand forms.

The result is registered with a one-cycle valid. One case is refused: an immediate-count operation in extended 128-bit mode with its 256-bit length flag set. A reserved element-size code is refused as well. A refused operation raises `illegal` together with `out_valid` and leaves the result register unchanged. The block has no status flags and raises no numeric exceptions.

Top module: `simd_lshift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `out_valid`, `illegal` and `result` to zero.
- R2: `elem_size` selects the element width. Code 0 gives 16-bit elements, code 1 gives 32-bit elements and code 2 gives 64-bit elements. Each element is shifted left on its own, its vacated low bits are filled with zeros, and no bit moves across an element boundary.
- R3: When `imm_sel` is 1, the shift amount is `imm_count`, zero-extended. When `imm_sel` is 0, the shift amount is `count_vec[63:0]` read as a full unsigned value, and `count_vec[127:64]` has no effect.
- R4: If the shift amount is equal to or greater than the element width, every active element of the result is zero. This applies to amounts such as 16 for words, 2^32 and 2^63.
- R5: With `width_mode` 0 (64-bit), `result[63:0]` is the shifted source and `result[255:64]` equals `old_dst[255:64]`. With `width_mode` 1 (legacy 128-bit), `result[127:0]` is the shifted source and `result[255:128]` equals `old_dst[255:128]`.
- R6: With `width_mode` 2 (extended 128-bit), `result[127:0]` is the shifted source and `result[255:128]` is zero. With `width_mode` 3 (256-bit), all 256 bits are the shifted source.
- R7: `out_valid` equals `in_valid` one clock earlier. An accepted operation appears on `result` exactly one cycle after the cycle in which it is presented.
- R8: An operation is illegal in two cases: when `width_mode` is 2 with `imm_sel` = 1 and `wide_len` = 1, and when `elem_size` is 3. An illegal operation gives `illegal` = 1 together with `out_valid` = 1 in the next cycle, and `result` keeps its previous value.
- R9: `illegal` is 0 for every legal operation and in every cycle where `out_valid` is 0. `wide_len` has no effect on register-count operations or on any mode other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| old_dst | input | 256 | Prior destination value, used for the preserved upper bits |
| src_vec | input | 256 | Vector to shift |
| count_vec | input | 128 | Register count operand; only bits 63:0 are read |
| imm_count | input | 8 | Immediate shift amount |
| imm_sel | input | 1 | 1 selects the immediate, 0 selects the register count |
| elem_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = reserved |
| width_mode | input | 2 | 0 = 64-bit, 1 = legacy 128, 2 = extended 128, 3 = 256-bit |
| wide_len | input | 1 | 256-bit length flag of the encoded operation |
| result | output | 256 | Registered shifted vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| illegal | output | 1 | Operation refused as an undefined form |

## Verification
Several behaviours are checked by assertions in every cycle. These are the one-cycle valid timing, the absence of `illegal` without `out_valid`, a held result after a refused operation, zeroed upper bits in extended 128-bit mode, preserved upper bits in legacy 128-bit mode, and an all-zero result for large immediate counts in 256-bit mode. Other behaviours can only be shown by the bench scenarios, which compare outputs against an independent bit-level model. These are the per-element shift contents for each of the three element sizes and the boundary amounts W-1, W and W+1. The bench also covers 64-bit register counts whose oversize bit sits high, such as 2^32 and 2^63, and confirms that count bits 127:64 are ignored.

// File: rtl/slu_pkg.sv
// Package: shared encodings for the packed left shifter.
// Assumes: element-size and width-mode codes are 2 bits, as at the top ports.
package slu_pkg;
    typedef enum logic [1:0] {
        ESZ_16  = 2'd0,
        ESZ_32  = 2'd1,
        ESZ_64  = 2'd2,
        ESZ_RSV = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        WM_64    = 2'd0,
        WM_L128  = 2'd1,
        WM_X128  = 2'd2,
        WM_256   = 2'd3
    } wmode_e;

    localparam int unsigned SEL_CNT_W = 64;
    localparam int unsigned NUM_ESZ   = 3;
endpackage

// File: rtl/slu_count_decode.sv
// Module: slu_count_decode
// Picks the shift amount from the immediate or from the low 64 bits of the
// count vector. Produces a 6-bit amount and one oversize flag per element size.
// Assumes: the largest element is 64 bits, and the register count is unsigned.
module slu_count_decode #(
    parameter int unsigned CNT_W = 128,
    parameter int unsigned IMM_W = 8
) (
    input  logic [CNT_W-1:0]                 count_vec,
    input  logic [IMM_W-1:0]                 imm_count,
    input  logic                             imm_sel,
    output logic [5:0]                       shamt,
    output logic [slu_pkg::NUM_ESZ-1:0]      kill
);
    import slu_pkg::*;

    logic [SEL_CNT_W-1:0] amount;
    logic                 unused_hi;

    // Count bits above the selected field never reach the shift.
    assign unused_hi = ^count_vec[CNT_W-1:SEL_CNT_W];

    // Select the count source, widening the immediate with zeros.
    always_comb begin
        if (imm_sel)
            amount = {{(SEL_CNT_W-IMM_W){1'b0}}, imm_count};
        else
            amount = count_vec[SEL_CNT_W-1:0];
    end

    assign shamt = amount[5:0];

    // Oversize detection per element size (16 << index).
    for (genvar gi = 0; gi < NUM_ESZ; gi++) begin : g_kill
        localparam longint unsigned LIM = 64'd16 << gi;
        assign kill[gi] = (amount >= LIM);
    end
endmodule

// File: rtl/slu_lane_shift.sv
// Module: slu_lane_shift
// Shifts each LANE_W-bit lane of a vector left by a shared amount, with zero
// fill. When kill is set, every lane is forced to zero.
// Assumes: VEC_W is a multiple of LANE_W, and shamt already fits in one lane.
module slu_lane_shift #(
    parameter int unsigned VEC_W  = 256,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned SH_W  = $clog2(LANE_W),
    localparam int unsigned LANES = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0] vec_in,
    input  logic [SH_W-1:0]  shamt,
    input  logic             kill,
    output logic [VEC_W-1:0] vec_out
);
    // One independent shifter for each lane.
    for (genvar li = 0; li < LANES; li++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        assign lane_in = vec_in[li*LANE_W +: LANE_W];
        assign vec_out[li*LANE_W +: LANE_W] = kill ? '0 : (lane_in << shamt);
    end
endmodule

// File: rtl/simd_lshift_unit.sv
// Module: simd_lshift_unit
// A packed logical left shifter with selectable element size, count source and
// register-width policy. The result is registered with one cycle of latency.
// Assumes: a synchronous active-low reset. Upper-bit policy comes from
// width_mode. old_dst carries the prior destination for the preserved bits.
module simd_lshift_unit #(
    parameter int unsigned VEC_W = 256,
    parameter int unsigned CNT_W = 128,
    parameter int unsigned IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] old_dst,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [CNT_W-1:0] count_vec,
    input  logic [IMM_W-1:0] imm_count,
    input  logic             imm_sel,
    input  logic [1:0]       elem_size,
    input  logic [1:0]       width_mode,
    input  logic             wide_len,
    output logic [VEC_W-1:0] result,
    output logic             out_valid,
    output logic             illegal
);
    import slu_pkg::*;

    localparam int unsigned QTR  = VEC_W / 4;
    localparam int unsigned HALF = VEC_W / 2;

    logic [5:0]         shamt;
    logic [NUM_ESZ-1:0] kill;
    logic [VEC_W-1:0]   shifted [NUM_ESZ];
    logic [VEC_W-1:0]   picked;
    logic [VEC_W-1:0]   merged;
    logic               bad_form;

    slu_count_decode #(.CNT_W(CNT_W), .IMM_W(IMM_W)) i_cnt (
        .count_vec (count_vec),
        .imm_count (imm_count),
        .imm_sel   (imm_sel),
        .shamt     (shamt),
        .kill      (kill)
    );

    // One lane shifter per element size; the lane width is 16 << index.
    for (genvar gi = 0; gi < NUM_ESZ; gi++) begin : g_esz
        localparam int unsigned LW = 16 << gi;
        slu_lane_shift #(.VEC_W(VEC_W), .LANE_W(LW)) i_lanes (
            .vec_in  (src_vec),
            .shamt   (shamt[$clog2(LW)-1:0]),
            .kill    (kill[gi]),
            .vec_out (shifted[gi])
        );
    end

    // Choose the shifter output that matches the element size.
    always_comb begin
        case (elem_size)
            ESZ_16:  picked = shifted[0];
            ESZ_32:  picked = shifted[1];
            default: picked = shifted[2];
        endcase
    end

    // Apply the upper-bit policy of the selected width mode.
    always_comb begin
        case (width_mode)
            WM_64:   merged = {old_dst[VEC_W-1:QTR], picked[QTR-1:0]};
            WM_L128: merged = {old_dst[VEC_W-1:HALF], picked[HALF-1:0]};
            WM_X128: merged = {{HALF{1'b0}}, picked[HALF-1:0]};
            default: merged = picked;
        endcase
    end

    // Undefined forms: reserved size, or immediate with the long flag in X128.
    assign bad_form = (elem_size == ESZ_RSV) ||
                      ((width_mode == WM_X128) && imm_sel && wide_len);

    // Output register: valid, illegal flag, and the result for legal operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid && bad_form;
            if (in_valid && !bad_form)
                result <= merged;
        end
    end

    // R7: valid follows the input by exactly one cycle.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: no illegal flag without a valid output.
    a_r9_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !illegal);

    // R8: a refused operation leaves the result untouched.
    a_r8_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> $stable(result));

    // R8: immediate form with the long flag in extended 128-bit mode is refused.
    a_r8_long_imm_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_mode == WM_X128 && imm_sel && wide_len) |=> illegal);

    // R6: extended 128-bit mode clears the upper half.
    a_r6_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_mode == WM_X128 && elem_size != ESZ_RSV &&
         !(imm_sel && wide_len)) |=> (result[VEC_W-1:HALF] == '0));

    // R5: legacy 128-bit mode keeps the old upper half.
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_mode == WM_L128 && elem_size != ESZ_RSV)
        |=> (result[VEC_W-1:HALF] == $past(old_dst[VEC_W-1:HALF])));

    // R4: an immediate of 64 or more clears every element in 256-bit mode.
    a_r4_big_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && imm_sel && imm_count >= 8'd64 && elem_size != ESZ_RSV &&
         width_mode == WM_256) |=> (result == '0));
endmodule

// File: tb/test_simd_lshift_unit.sv
`timescale 1ns/1ps
module test_simd_lshift_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] old_dst = '0;
    logic [255:0] src_vec = '0;
    logic [127:0] count_vec = '0;
    logic [7:0]   imm_count = '0;
    logic         imm_sel = 1'b0;
    logic [1:0]   elem_size = '0;
    logic [1:0]   width_mode = '0;
    logic         wide_len = 1'b0;
    logic [255:0] result;
    logic         out_valid;
    logic         illegal;

    int checks = 0;
    int failures = 0;
    logic [255:0] exp_hold = '0;

    always #2.5 clk = ~clk;

    simd_lshift_unit i_simd_lshift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .old_dst(old_dst),
        .src_vec(src_vec), .count_vec(count_vec), .imm_count(imm_count),
        .imm_sel(imm_sel), .elem_size(elem_size), .width_mode(width_mode),
        .wide_len(wide_len), .result(result), .out_valid(out_valid),
        .illegal(illegal)
    );

    // Bit-level model built from the requirements.
    function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] o,
            input logic [127:0] cv, input logic [7:0] im, input logic isel,
            input logic [1:0] esz, input logic [1:0] md);
        int w;
        longint unsigned c;
        int ci;
        logic [255:0] sh;
        w  = (esz == 2'd0) ? 16 : (esz == 2'd1) ? 32 : 64;
        c  = isel ? {56'd0, im} : cv[63:0];
        ci = (c < longint'(w)) ? int'(c) : w;
        sh = '0;
        for (int b = 0; b < 256; b++)
            if (ci < w && (b % w) >= ci) sh[b] = s[b - ci];
        case (md)
            2'd0: return {o[255:64], sh[63:0]};
            2'd1: return {o[255:128], sh[127:0]};
            2'd2: return {128'd0, sh[127:0]};
            default: return sh;
        endcase
    endfunction

    function automatic logic refused(input logic isel, input logic [1:0] esz,
            input logic [1:0] md, input logic wl);
        return (esz == 2'd3) || (md == 2'd2 && isel && wl);
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one operation, then check it one cycle later.
    task automatic run_op(input string tag, input logic [255:0] s, input logic [255:0] o,
            input logic [127:0] cv, input logic [7:0] im, input logic isel,
            input logic [1:0] esz, input logic [1:0] md, input logic wl);
        logic bad;
        @(negedge clk);
        in_valid = 1'b1; src_vec = s; old_dst = o; count_vec = cv;
        imm_count = im; imm_sel = isel; elem_size = esz; width_mode = md; wide_len = wl;
        bad = refused(isel, esz, md, wl);
        if (!bad) exp_hold = model(s, o, cv, im, isel, esz, md);
        @(posedge clk); #1;
        check({tag, " valid (R7)"}, {255'd0, out_valid}, 256'd1);
        check({tag, " illegal (R8/R9)"}, {255'd0, illegal}, {255'd0, bad});
        check({tag, " result"}, result, exp_hold);
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [255:0] pat;
        logic [255:0] old;
        void'($urandom(32'h5EED));
        pat = {8{32'hA5C3_9E17}};
        old = {8{32'h1234_5678}};
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid", {255'd0, out_valid}, '0);
        check("R1 illegal", {255'd0, illegal}, '0);
        check("R1 result", result, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2: each element size, with the count taken from the register.
        run_op("R2 word sh4",   pat, old, 128'd4,  8'd0, 1'b0, 2'd0, 2'd3, 1'b0);
        run_op("R2 dword sh31", pat, old, 128'd31, 8'd0, 1'b0, 2'd1, 2'd3, 1'b0);
        run_op("R2 qword sh0",  pat, old, 128'd0,  8'd0, 1'b0, 2'd2, 2'd3, 1'b0);
        run_op("R2 qword sh63", pat, old, 128'd63, 8'd0, 1'b0, 2'd2, 2'd3, 1'b0);
        run_op("R2 word sh15",  pat, old, 128'd15, 8'd0, 1'b0, 2'd0, 2'd3, 1'b0);
        // R4: boundary counts W and W+1, immediate 16, 2^32 and 2^63.
        run_op("R4 word sh16",  pat, old, 128'd16, 8'd0, 1'b0, 2'd0, 2'd3, 1'b0);
        run_op("R4 dword sh33", pat, old, 128'd33, 8'd0, 1'b0, 2'd1, 2'd3, 1'b0);
        run_op("R4 qword sh64", pat, old, 128'd64, 8'd0, 1'b0, 2'd2, 2'd3, 1'b0);
        run_op("R4 imm16 word", pat, old, 128'd0,  8'd16, 1'b1, 2'd0, 2'd3, 1'b0);
        run_op("R4 cnt 2^32",   pat, old, 128'h1_0000_0000, 8'd0, 1'b0, 2'd2, 2'd3, 1'b0);
        run_op("R4 cnt 2^63",   pat, old, {64'd0, 64'h8000_0000_0000_0000}, 8'd0, 1'b0, 2'd0, 2'd3, 1'b0);
        // R3: upper count bits ignored, and the immediate selected over the register.
        run_op("R3 hi ignored", pat, old, {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, 8'd0, 1'b0, 2'd1, 2'd3, 1'b0);
        run_op("R3 imm select", pat, old, 128'd60, 8'd5, 1'b1, 2'd1, 2'd3, 1'b0);
        // R5 and R6: width policies.
        run_op("R5 mode64",     pat, old, 128'd2, 8'd0, 1'b0, 2'd0, 2'd0, 1'b0);
        run_op("R5 legacy128",  pat, old, 128'd2, 8'd0, 1'b0, 2'd1, 2'd1, 1'b0);
        run_op("R6 ext128",     pat, old, 128'd2, 8'd0, 1'b0, 2'd1, 2'd2, 1'b0);
        // R8: refused forms leave the result as it was.
        run_op("R8 long imm",   ~pat, old, 128'd0, 8'd1, 1'b1, 2'd0, 2'd2, 1'b1);
        run_op("R8 rsv size",   ~pat, old, 128'd1, 8'd0, 1'b0, 2'd3, 2'd3, 1'b0);
        // R9: the long flag does not refuse the register form or the other modes.
        run_op("R9 long reg",   pat, old, 128'd1, 8'd0, 1'b0, 2'd0, 2'd2, 1'b1);
        run_op("R9 long 256",   pat, old, 128'd0, 8'd7, 1'b1, 2'd2, 2'd3, 1'b1);

        // Random mix of operations.
        for (int n = 0; n < 400; n++) begin
            logic [127:0] cv;
            logic [7:0]   im;
            cv = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(3) != 0) cv[63:0] = 64'($urandom_range(70));
            im = ($urandom_range(1) == 1) ? 8'($urandom_range(70)) : 8'($urandom);
            run_op("R2 random", rnd256(), rnd256(), cv, im, 1'($urandom),
                   2'($urandom), 2'($urandom), 1'($urandom));
        end

        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check("R7 idle", {255'd0, out_valid}, '0);
        check("R9 idle", {255'd0, illegal}, '0);
        report();
    end
endmodule